// File: doc/BRIEF.md
# Spiking Threshold-Neuron Binary Adder

This block adds two unsigned P-bit operands with a small fixed network of integrate-and-fire neurons. It has no logic gates on the sum path. Every neuron rests at a potential of -1 and has zero leak. On each time step it adds the weighted spikes that arrive in that step and fires if the total reaches its threshold. After every step it returns to -1, whether or not it fired. Synapses carry a spike with weight +1 or -1 and a fixed delay of one or more steps.

For each bit position a small group of neurons counts the spikes that arrive there: the operand bits and the carry coming up from the position below. The neuron with threshold 0 fires when the count is at least one, the one with threshold 1 when it is at least two, and the one with threshold 2 when it is three. The threshold-1 neuron is also the carry into the next group. An output neuron adds the threshold-0 and threshold-2 spikes and subtracts the threshold-1 spike, which gives the sum bit. The synapse delays are chosen so that every sum bit fires in the same step.

Time advances only on clock edges where `tick` is high. An operand pair is taken in with `start` on such an edge. The result appears P+2 steps later and stays for exactly one step. The next pair can be taken in on the tick that follows.

Top module: `snn_spike_adder`

## Requirements
- R1: While reset is applied and after it is released, `z_out` is zero and `z_valid` is low. A `start` presented during reset produces no result afterwards.
- R2: After a pair is accepted on a tick, `z_valid` goes high on the (P+2)-th following tick and falls on the next tick. At all other times it stays low.
- R3: While `z_valid` is high, `z_out` equals x_in + y_in as a (P+1)-bit unsigned value, with bit i weighted 2^i and bit P as the final carry.
- R4: Whenever `z_valid` is low, `z_out` is all zero, so all output bits fire together and only in the result step.
- R5: `start` is sampled only on clock edges where `tick` is high. A `start` on any other edge has no effect.
- R6: A `start` from the accepting tick up to and including the tick that raises `z_valid` is ignored. It changes neither the pending result nor the timing, and it produces no second result.
- R7: `z_out` and `z_valid` change only on clock edges where `tick` is high.
- R8: `x_in` and `y_in` are sampled only on the accepting tick. Values driven later do not change the result.
- R9: A carry ripples through every position. All-ones plus one gives only bit P set, and all-ones plus all-ones gives 2^(P+1)-2.
- R10: A new pair is accepted on the tick right after the one that raised `z_valid`, so one sum completes every P+3 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; internally released in step with the clock |
| tick | input | 1 | Time-step enable; one network step per clock edge with tick high |
| start | input | 1 | Request to take in x_in and y_in on this tick |
| x_in | input | P | First operand, one spike per bit |
| y_in | input | P | Second operand, one spike per bit |
| z_out | output | P+1 | Sum spikes, bit i weighted 2^i |
| z_valid | output | 1 | High for the single step in which z_out carries the sum |

## Verification
With a narrow width, every operand pair is applied back to back. This separates a wrong sum or carry decision in any group from a misaligned delay, because a misaligned delay moves a sum bit out of the one result step. Directed pairs then test the longest carry ripple, all-ones plus all-ones, and zero plus zero, where the valid flag must still rise with an all-zero sum. Further runs use randomly spaced ticks and operands that change while an addition is in flight. They also drive start pulses off the tick and during an addition. These runs show whether state moves only on ticks and whether inputs are sampled only at acceptance.

// File: rtl/snn_add_pkg.sv
package snn_add_pkg;

  // Membrane potential: fan-in is at most three spikes on top of the rest level.
  localparam int POT_W = 4;
  typedef logic signed [POT_W-1:0] pot_t;
  localparam pot_t REST_POT = -4'sd1;

  // Neurons in the group for bit idx: the least significant group lacks threshold 2.
  function automatic int group_size(input int idx);
    return (idx == 0) ? 2 : 3;
  endfunction

  // Incoming synapses per neuron in group idx: x, y and carry as applicable.
  function automatic int group_fanin(input int idx, input int p);
    if (idx == 0) return 2;
    if (idx == p) return 1;
    return 3;
  endfunction

  // Delay of fan-in slot j of group idx (slots: 0 = x, 1 = y, 2 = carry).
  function automatic int fanin_delay(input int idx, input int p, input int j);
    if (idx == p) return 1;
    if (j < 2) return idx + 1;
    return 1;
  endfunction

  // Delay from group idx to its output neuron, aligning all outputs.
  function automatic int out_delay(input int idx, input int p);
    return p - idx + 1;
  endfunction

endpackage

// File: rtl/snn_rst_sync.sv
module snn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_n;

  always_comb sync_n = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_n;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/snn_delay_line.sv
module snn_delay_line #(
  parameter int DELAY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic d,
  output logic q
);
  // The neuron register at the source already supplies one step,
  // so a delay of D needs D-1 extra stages.
  generate
    if (DELAY <= 1) begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, tick};
      assign q = d;
    end else begin : g_shift
      localparam int DEPTH = DELAY - 1;
      logic [DEPTH-1:0] sh_q;
      logic [DEPTH-1:0] sh_n;

      if (DEPTH == 1) begin : g_one
        always_comb sh_n = d;
      end else begin : g_many
        always_comb sh_n = {sh_q[DEPTH-2:0], d};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sh_q <= '0;
        else if (tick) sh_q <= sh_n;
      end

      assign q = sh_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/snn_neuron.sv
module snn_neuron
  import snn_add_pkg::*;
#(
  parameter int             NIN      = 1,
  parameter int             THRESH   = 0,
  parameter logic [NIN-1:0] INH_MASK = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NIN-1:0] spk_in,
  output logic           spike
);
  pot_t acc;
  logic fire_n;

  // Zero leak: each step starts from rest, integrates, compares.
  always_comb begin
    acc = REST_POT;
    for (int j = 0; j < NIN; j++) begin
      if (spk_in[j]) begin
        if (INH_MASK[j]) acc = acc - pot_t'(1);
        else             acc = acc + pot_t'(1);
      end
    end
    fire_n = (acc >= pot_t'(THRESH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    spike <= 1'b0;
    else if (tick) spike <= fire_n;
  end
endmodule

// File: rtl/snn_bit_group.sv
module snn_bit_group
  import snn_add_pkg::*;
#(
  parameter int P   = 8,
  parameter int IDX = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic x_spk,
  input  logic y_spk,
  input  logic c_in,
  output logic c_out,
  output logic z_spk
);
  localparam int NN = group_size(IDX);
  localparam int NF = group_fanin(IDX, P);

  logic [NF-1:0] src;
  logic [NN-1:0] nspk;
  logic [NN-1:0] oarr;
  logic          unused_in;

  generate
    if (IDX == P) begin : g_top
      assign src[0]    = c_in;
      assign unused_in = ^{x_spk, y_spk};
    end else if (IDX == 0) begin : g_lsb
      assign src       = {y_spk, x_spk};
      assign unused_in = c_in;
    end else begin : g_mid
      assign src       = {c_in, y_spk, x_spk};
      assign unused_in = 1'b0;
    end

    // Neuron k has threshold k; every synapse has its own delay line.
    for (genvar k = 0; k < NN; k++) begin : g_n
      logic [NF-1:0] arr;
      for (genvar j = 0; j < NF; j++) begin : g_syn
        snn_delay_line #(.DELAY(fanin_delay(IDX, P, j))) u_dl (
          .clk(clk), .rst_n(rst_n), .tick(tick), .d(src[j]), .q(arr[j])
        );
      end
      snn_neuron #(.NIN(NF), .THRESH(k), .INH_MASK('0)) u_nrn (
        .clk(clk), .rst_n(rst_n), .tick(tick), .spk_in(arr), .spike(nspk[k])
      );
      snn_delay_line #(.DELAY(out_delay(IDX, P))) u_odl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .d(nspk[k]), .q(oarr[k])
      );
    end
  endgenerate

  // Output neuron: threshold-1 input is inhibitory and cancels threshold-0.
  snn_neuron #(.NIN(NN), .THRESH(0), .INH_MASK(NN'(2))) u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .spk_in(oarr), .spike(z_spk)
  );

  assign c_out = nspk[1];
endmodule

// File: rtl/snn_step_seq.sv
module snn_step_seq #(
  parameter int P = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic accept,
  output logic z_valid
);
  localparam int LAST = P + 1;
  localparam int CW   = $clog2(P + 3) + 1;

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          vld_n;

  assign accept = tick & start & ~busy_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    vld_n  = busy_q && (cnt_q == CW'(LAST));
    if (accept) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q) begin
      cnt_n = cnt_q + CW'(1);
      if (cnt_q == CW'(LAST)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      z_valid <= 1'b0;
    end else if (tick) begin
      busy_q  <= busy_n;
      cnt_q   <= cnt_n;
      z_valid <= vld_n;
    end
  end
endmodule

// File: rtl/snn_spike_adder.sv
module snn_spike_adder #(
  parameter int P = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic [P-1:0] x_in,
  input  logic [P-1:0] y_in,
  output logic [P:0]   z_out,
  output logic         z_valid
);
  logic         rst_sync_n;
  logic         accept;
  logic [P-1:0] xs;
  logic [P-1:0] ys;
  logic [P:0]   carry;
  logic         unused_carry;

  snn_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  snn_step_seq #(.P(P)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .start(start),
    .accept(accept), .z_valid(z_valid)
  );

  assign carry[0] = 1'b0;

  generate
    // Input neurons: threshold 0, fire in the accepting step.
    for (genvar i = 0; i < P; i++) begin : g_in
      snn_neuron #(.NIN(1), .THRESH(0), .INH_MASK(1'b0)) u_xn (
        .clk(clk), .rst_n(rst_sync_n), .tick(tick),
        .spk_in(accept & x_in[i]), .spike(xs[i])
      );
      snn_neuron #(.NIN(1), .THRESH(0), .INH_MASK(1'b0)) u_yn (
        .clk(clk), .rst_n(rst_sync_n), .tick(tick),
        .spk_in(accept & y_in[i]), .spike(ys[i])
      );
    end

    for (genvar i = 0; i <= P; i++) begin : g_bit
      if (i < P) begin : g_low
        snn_bit_group #(.P(P), .IDX(i)) u_grp (
          .clk(clk), .rst_n(rst_sync_n), .tick(tick),
          .x_spk(xs[i]), .y_spk(ys[i]), .c_in(carry[i]),
          .c_out(carry[i+1]), .z_spk(z_out[i])
        );
      end else begin : g_msb
        snn_bit_group #(.P(P), .IDX(i)) u_grp (
          .clk(clk), .rst_n(rst_sync_n), .tick(tick),
          .x_spk(1'b0), .y_spk(1'b0), .c_in(carry[i]),
          .c_out(unused_carry), .z_spk(z_out[i])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/snn_spike_adder_chk.sv
module snn_spike_adder_chk #(
  parameter int P = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         start,
  input logic [P-1:0] x_in,
  input logic [P-1:0] y_in,
  input logic [P:0]   z_out,
  input logic         z_valid
);
  localparam int CW = $clog2(P + 3) + 1;

  logic          m_busy;
  logic [CW-1:0] m_cnt;
  logic [P-1:0]  m_x;
  logic [P-1:0]  m_y;
  logic          m_last;

  assign m_last = m_busy && (m_cnt == CW'(P + 1));

  // Independent operation tracker counting ticks since acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_cnt  <= '0;
      m_x    <= '0;
      m_y    <= '0;
    end else if (tick) begin
      if (start && !m_busy) begin
        m_busy <= 1'b1;
        m_cnt  <= '0;
        m_x    <= x_in;
        m_y    <= y_in;
      end else if (m_busy) begin
        m_cnt <= m_cnt + CW'(1);
        if (m_last) m_busy <= 1'b0;
      end
    end
  end

  AST_VALID_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && m_last) |=> z_valid); // R2
  AST_VALID_ONLY_THEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !m_last) |=> !z_valid); // R6
  AST_SUM_CORRECT: assert property (@(posedge clk) disable iff (!rst_n)
    z_valid |-> (z_out == ({1'b0, m_x} + {1'b0, m_y}))); // R3
  AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !z_valid |-> (z_out == '0)); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(z_out) && $stable(z_valid))); // R7
endmodule

bind snn_spike_adder snn_spike_adder_chk #(.P(P)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .start(start),
  .x_in(x_in), .y_in(y_in), .z_out(z_out), .z_valid(z_valid)
);

// File: tb/snn_spike_adder_tb.sv
module snn_spike_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 6;
  localparam int WD_CYCLES  = 190000;

  logic         clk;
  logic         rst_n;
  logic         tick;
  logic         start;
  logic [P-1:0] x_in;
  logic [P-1:0] y_in;
  logic [P:0]   z_out;
  logic         z_valid;

  int checks   = 0;
  int failures = 0;
  logic [P:0] s_z;
  logic       s_v;

  snn_spike_adder #(.P(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .x_in(x_in), .y_in(y_in), .z_out(z_out), .z_valid(z_valid)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [P:0] ref_sum(input logic [P-1:0] a, input logic [P-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // One network step: tick for one clock, then gap clocks with tick low,
  // where start is driven high (jhi) or randomly to probe off-tick sampling.
  task automatic tick_step(input logic st, input logic [P-1:0] xv, input logic [P-1:0] yv,
                           input int gap_max, input logic jhi);
    int gap;
    gap = int'($urandom_range(gap_max, 0));
    @(negedge clk);
    tick = 1'b1; start = st; x_in = xv; y_in = yv;
    @(negedge clk);
    tick = 1'b0;
    start = jhi ? 1'b1 : 1'($urandom);
    x_in = P'($urandom); y_in = P'($urandom);
    s_z = z_out; s_v = z_valid;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      start = jhi ? 1'b1 : 1'($urandom);
      chk("R7", {31'd0, z_valid}, {31'd0, s_v});
      chk("R7", 32'(z_out), 32'(s_z));
    end
    start = 1'b0;
  endtask

  // Full operation: accept, P+1 silent steps, result step.
  task automatic run_op(input logic [P-1:0] xv, input logic [P-1:0] yv, input string tag,
                        input logic intrude, input int gap_max);
    logic [P:0] exp_z;
    exp_z = ref_sum(xv, yv);
    tick_step(1'b1, xv, yv, gap_max, 1'b0);
    chk("R2", {31'd0, s_v}, 32'd0);
    chk("R4", 32'(s_z), 32'd0);
    for (int k = 1; k <= P + 1; k++) begin
      tick_step(intrude, P'($urandom), P'($urandom), gap_max, 1'b0); // R8 junk operands
      chk("R2", {31'd0, s_v}, 32'd0);
      chk("R4", 32'(s_z), 32'd0);
    end
    tick_step(intrude, P'($urandom), P'($urandom), gap_max, 1'b0);
    chk("R2", {31'd0, s_v}, 32'd1);
    chk(tag, 32'(s_z), 32'(exp_z));
  endtask

  task automatic idle_steps(input string tag, input int n, input logic jhi);
    for (int k = 0; k < n; k++) begin
      tick_step(1'b0, P'($urandom), P'($urandom), 2, jhi);
      chk(tag, {31'd0, s_v}, 32'd0);
      chk(tag, 32'(s_z), 32'd0);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [P-1:0] ones;
    void'($urandom(32'd20240917));
    ones  = '1;
    rst_n = 1'b0; tick = 1'b0; start = 1'b0; x_in = '0; y_in = '0;

    // R1: reset state, with a start attempt while reset is held
    repeat (2) @(negedge clk);
    tick = 1'b1; start = 1'b1; x_in = ones; y_in = ones;
    repeat (2) @(negedge clk);
    chk("R1", {31'd0, z_valid}, 32'd0);
    chk("R1", 32'(z_out), 32'd0);
    tick = 1'b0; start = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", {31'd0, z_valid}, 32'd0);
    chk("R1", 32'(z_out), 32'd0);
    idle_steps("R1", P + 3, 1'b0);

    // R5: start held high only on off-tick clocks never starts an operation
    idle_steps("R5", P + 3, 1'b1);

    // Directed corner cases
    run_op(6'd3, 6'd1, "R3", 1'b0, 0);
    run_op(ones, 6'd1, "R9", 1'b0, 0);
    run_op(ones, ones, "R9", 1'b0, 1);
    run_op(6'd0, 6'd0, "R3", 1'b0, 2);
    run_op(6'b101010, 6'b010101, "R8", 1'b0, 2);
    run_op(6'd17, 6'd46, "R10", 1'b0, 0);

    // R6: start with other operands on every tick while busy
    run_op(6'd9, 6'd22, "R6", 1'b1, 1);
    idle_steps("R6", P + 3, 1'b0);

    // Exhaustive sweep, back to back (R10)
    for (int a = 0; a < (1 << P); a++) begin
      for (int b = 0; b < (1 << P); b++) begin
        run_op(P'(a), P'(b), "R3", 1'b0, 0);
      end
    end

    // Random operands with random tick spacing and intrusions
    for (int r = 0; r < 150; r++) begin
      run_op(P'($urandom), P'($urandom), "R3", 1'($urandom), 2);
    end
    idle_steps("R6", P + 3, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule